// File: doc/BRIEF.md
# Direct-Mapped Data Cache with Deferred Store Write

This block is the memory-stage data cache of a simple in-order pipeline. It is direct mapped and write-through, and it does not allocate on a store miss. A load checks the tags and reads the data array in the same cycle as its request, so hit flag and load data are combinational from the request. A normal store costs two array cycles: one for the tag check and one for the data write. This block hides the second cycle. A store that hits is parked in a single pending-write register holding the word address, the data and the byte enables. The parked data enters the data array in the cycle of the next store, during that store's own tag check.

Loads that name the parked word merge the parked bytes over the array bytes, byte by byte, so a load never sees stale data. Every accepted store is also presented on a write-through port toward the next memory level. Lines arrive whole from the lower level through a one-cycle fill port. A fill takes the whole cycle, and a fill that lands on the index of the parked word discards the parked word.

Top module: `dwc_cache`

## Requirements
- R1: `req_addr` is a word address. Bits [OFF_W-1:0] select the word in the line, the next INDEX_W bits select the line, and the remaining upper bits are the tag. For an accepted request, `rsp_hit` is 1 in the same cycle exactly when that line is valid and its stored tag equals the request tag.
- R2: While `rst_n` is low at a clock edge, every line becomes invalid and the pending write is discarded. After reset, every load misses.
- R3: A fill with `fill_valid`=1 writes the whole line: word w is taken from `fill_data[w*DATA_W +: DATA_W]`. The line at index `fill_addr[INDEX_W-1:0]` becomes valid, with tag `fill_addr[LADDR_W-1:INDEX_W]`. From the next cycle, loads to that line hit and return the filled words.
- R4: A store that hits is held in the pending register and is not written to the array in its own cycle. A later load of the same word returns the stored bytes, taken from the pending register if the store has not yet been committed.
- R5: Bit j of `req_be` enables byte j, which is bits [8j+7:8j] of the word. A store changes only its enabled bytes, and the load merge replaces only the bytes that the pending store enabled.
- R6: When a store is accepted while a write is pending, the pending word is committed to the array and the new store takes the register in the same cycle. Back-to-back stores to the same or to different words leave all of them readable.
- R7: A store that misses returns `rsp_hit`=0 and allocates no line. It still commits any older pending write, and it leaves the pending register empty.
- R8: Every accepted store appears in the same cycle on the write-through port: `wt_valid`=1, with its address, data and byte enables.
- R9: A fill whose index equals the pending word's index discards the pending write, so the refilled line is never overwritten. A fill to any other index keeps the pending write.
- R10: While `fill_valid` is 1, the request is not accepted: `rsp_hit`=0 and `wt_valid`=0, and a store presented in that cycle has no effect on the cache.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Word address of the request |
| req_wdata | input | DATA_W | Store data |
| req_be | input | DATA_W/8 | Store byte enables |
| rsp_hit | output | 1 | Request hit (same cycle) |
| rsp_rdata | output | DATA_W | Load data, with pending bytes merged in |
| wt_valid | output | 1 | Write-through store valid |
| wt_addr | output | ADDR_W | Write-through word address |
| wt_data | output | DATA_W | Write-through data |
| wt_be | output | DATA_W/8 | Write-through byte enables |
| fill_valid | input | 1 | Line fill this cycle |
| fill_addr | input | ADDR_W-OFF_W | Line address of the fill (tag and index) |
| fill_data | input | DATA_W*2^OFF_W | Whole line of fill data |

## Verification
The bench aims at the following cases:
- A load straight after a store to the same word, under every byte-enable pattern. A missing or whole-word bypass returns old bytes or stray bytes.
- Two stores to one word back to back with disjoint enables. A design that overwrites the register without committing it first loses the first store's bytes.
- A store that misses straight after a store that hit. This catches allocation on a store miss and a pending register left set.
- A refill on the pending index, followed by a later store. A pending write that is kept and then committed corrupts the refilled line.
- A store presented during a fill. If it is not blocked, it leaks onto the write-through port or into the array.

A random mixed run compares every load against a model of memory in which cache contents always equal memory.

// File: rtl/dwc_pkg.sv
// Package: shared types for the deferred-store data cache.
// Assumes: one request or one fill per cycle; a fill takes precedence.
package dwc_pkg;

    // Operation carried out by the cache in a given cycle
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_LOAD  = 2'd1,
        OP_STORE = 2'd2,
        OP_FILL  = 2'd3
    } dwc_op_e;

    // Decode the cycle's operation; a fill blocks the CPU request
    function automatic dwc_op_e decode_op(input logic fill, input logic valid,
                                          input logic store);
        if (fill)        return OP_FILL;
        else if (!valid) return OP_IDLE;
        else if (store)  return OP_STORE;
        else             return OP_LOAD;
    endfunction

endpackage

// File: rtl/dwc_tag_store.sv
// Module: tag and valid storage of a direct-mapped cache with a single
// combinational lookup port and a single fill port.
// Assumes: a fill and a lookup may occur in the same cycle; the lookup
// then sees the old contents (the top blocks lookups during fills anyway).
module dwc_tag_store #(
    parameter int INDEX_W = 4,
    parameter int TAG_W   = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INDEX_W-1:0] rd_index,
    input  logic [TAG_W-1:0]   rd_tag,
    output logic               rd_hit,
    input  logic               fill_en,
    input  logic [INDEX_W-1:0] fill_index,
    input  logic [TAG_W-1:0]   fill_tag
);
    localparam int LINES = 1 << INDEX_W;

    logic [LINES-1:0] valid_q;
    logic [TAG_W-1:0] tag_q [LINES];

    // Valid bits: cleared by reset, set by a fill
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (fill_en) begin
            valid_q[fill_index] <= 1'b1;
        end
    end

    // Tag storage: written by a fill, no reset needed (qualified by valid)
    always_ff @(posedge clk) begin
        if (fill_en) begin
            tag_q[fill_index] <= fill_tag;
        end
    end

    // Hit compare: valid line with matching tag
    always_comb begin
        rd_hit = valid_q[rd_index] && (tag_q[rd_index] == rd_tag);
    end

endmodule

// File: rtl/dwc_data_store.sv
// Module: data storage of the cache; one combinational word read port,
// one whole-line fill port and one byte-masked word write port.
// Assumes: fill and word write never target the same cycle (the top
// only commits on an accepted store, and a fill blocks stores).
module dwc_data_store #(
    parameter int INDEX_W = 4,
    parameter int OFF_W   = 2,
    parameter int DATA_W  = 32
) (
    input  logic                      clk,
    input  logic [INDEX_W-1:0]        rd_index,
    input  logic [OFF_W-1:0]          rd_off,
    output logic [DATA_W-1:0]         rd_word,
    input  logic                      fill_en,
    input  logic [INDEX_W-1:0]        fill_index,
    input  logic [(DATA_W<<OFF_W)-1:0] fill_line,
    input  logic                      wr_en,
    input  logic [INDEX_W-1:0]        wr_index,
    input  logic [OFF_W-1:0]          wr_off,
    input  logic [DATA_W-1:0]         wr_data,
    input  logic [DATA_W/8-1:0]       wr_be
);
    localparam int LINES = 1 << INDEX_W;
    localparam int WORDS = 1 << OFF_W;
    localparam int BE_W  = DATA_W / 8;

    logic [DATA_W-1:0] mem_q   [LINES][WORDS];
    logic [DATA_W-1:0] fill_w  [WORDS];
    logic [DATA_W-1:0] wr_mrg;

    // Unpack the fill line into words
    for (genvar w = 0; w < WORDS; w++) begin : g_fill_unpack
        assign fill_w[w] = fill_line[w*DATA_W +: DATA_W];
    end

    // Merge commit data over the current word, byte lane by byte lane
    for (genvar b = 0; b < BE_W; b++) begin : g_wr_lane
        assign wr_mrg[b*8 +: 8] = wr_be[b] ? wr_data[b*8 +: 8]
                                           : mem_q[wr_index][wr_off][b*8 +: 8];
    end

    // Array update: whole-line fill or single-word commit
    always_ff @(posedge clk) begin
        if (fill_en) begin
            for (int w = 0; w < WORDS; w++) begin
                mem_q[fill_index][w] <= fill_w[w];
            end
        end else if (wr_en) begin
            mem_q[wr_index][wr_off] <= wr_mrg;
        end
    end

    // Combinational word read
    always_comb begin
        rd_word = mem_q[rd_index][rd_off];
    end

endmodule

// File: rtl/dwc_pend_buf.sv
// Module: single delayed-write register with byte-merging load bypass.
// Captures a store that hit; empties on a store miss or on a fill that
// lands on its index; presents its contents for commit by the top.
// Assumes: store_evt and fill_en are never both 1 in a cycle.
module dwc_pend_buf #(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 32,
    parameter int INDEX_W = 4,
    parameter int OFF_W   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               store_evt,
    input  logic               store_hit,
    input  logic [ADDR_W-1:0]  cap_addr,
    input  logic [DATA_W-1:0]  cap_data,
    input  logic [DATA_W/8-1:0] cap_be,
    input  logic               fill_en,
    input  logic [INDEX_W-1:0] fill_index,
    output logic               pend_valid,
    output logic [INDEX_W-1:0] pend_index,
    output logic [OFF_W-1:0]   pend_off,
    output logic [DATA_W-1:0]  pend_data,
    output logic [DATA_W/8-1:0] pend_be,
    input  logic [ADDR_W-1:0]  look_addr,
    input  logic [DATA_W-1:0]  arr_word,
    output logic [DATA_W-1:0]  merged_word
);
    localparam int BE_W = DATA_W / 8;

    logic               valid_q;
    logic [ADDR_W-1:0]  addr_q;
    logic [DATA_W-1:0]  data_q;
    logic [BE_W-1:0]    be_q;
    logic               drop;
    logic               look_match;

    // A fill on the pending index discards the pending word
    assign drop = fill_en && (addr_q[OFF_W +: INDEX_W] == fill_index);

    // Pending valid flag: set by a store hit, cleared by miss, drop, reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
        end else if (store_evt) begin
            valid_q <= store_hit;
        end else if (drop) begin
            valid_q <= 1'b0;
        end
    end

    // Pending payload: loaded on every store hit
    always_ff @(posedge clk) begin
        if (store_evt && store_hit) begin
            addr_q <= cap_addr;
            data_q <= cap_data;
            be_q   <= cap_be;
        end
    end

    // Bypass match: the load names exactly the pending word
    assign look_match = valid_q && (addr_q == look_addr);

    // Per-byte merge of pending bytes over array bytes
    for (genvar b = 0; b < BE_W; b++) begin : g_merge_lane
        assign merged_word[b*8 +: 8] = (look_match && be_q[b]) ? data_q[b*8 +: 8]
                                                               : arr_word[b*8 +: 8];
    end

    assign pend_valid = valid_q;
    assign pend_index = addr_q[OFF_W +: INDEX_W];
    assign pend_off   = addr_q[OFF_W-1:0];
    assign pend_data  = data_q;
    assign pend_be    = be_q;

endmodule

// File: rtl/dwc_cache.sv
// Module: direct-mapped write-through data cache with deferred store
// write. Load hit and data are combinational from the request. A store
// hit is parked and written to the array during the next store's cycle.
// Assumes: word addressing; a fill occupies the whole cycle and blocks
// the CPU request; no allocation on a store miss.
module dwc_cache #(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 32,
    parameter int INDEX_W = 4,
    parameter int OFF_W   = 2,
    localparam int TAG_W   = ADDR_W - INDEX_W - OFF_W,
    localparam int LADDR_W = ADDR_W - OFF_W,
    localparam int BE_W    = DATA_W / 8,
    localparam int LINE_W  = DATA_W << OFF_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_store,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [DATA_W-1:0]  req_wdata,
    input  logic [BE_W-1:0]    req_be,
    output logic               rsp_hit,
    output logic [DATA_W-1:0]  rsp_rdata,
    output logic               wt_valid,
    output logic [ADDR_W-1:0]  wt_addr,
    output logic [DATA_W-1:0]  wt_data,
    output logic [BE_W-1:0]    wt_be,
    input  logic               fill_valid,
    input  logic [LADDR_W-1:0] fill_addr,
    input  logic [LINE_W-1:0]  fill_data
);
    import dwc_pkg::*;

    dwc_op_e            op;
    logic               accepted;
    logic               store_evt;
    logic               tag_hit;
    logic [INDEX_W-1:0] req_index;
    logic [OFF_W-1:0]   req_off;
    logic [TAG_W-1:0]   req_tag;
    logic [INDEX_W-1:0] fill_index;
    logic [TAG_W-1:0]   fill_tag;
    logic               pend_valid;
    logic [INDEX_W-1:0] pend_index;
    logic [OFF_W-1:0]   pend_off;
    logic [DATA_W-1:0]  pend_data;
    logic [BE_W-1:0]    pend_be;
    logic [DATA_W-1:0]  arr_word;
    logic               commit_en;

    // Field split of the request and fill addresses
    assign req_off    = req_addr[OFF_W-1:0];
    assign req_index  = req_addr[OFF_W +: INDEX_W];
    assign req_tag    = req_addr[ADDR_W-1 -: TAG_W];
    assign fill_index = fill_addr[INDEX_W-1:0];
    assign fill_tag   = fill_addr[LADDR_W-1 -: TAG_W];

    // Cycle operation decode
    always_comb begin
        op        = decode_op(fill_valid, req_valid, req_store);
        accepted  = (op == OP_LOAD) || (op == OP_STORE);
        store_evt = (op == OP_STORE);
        commit_en = store_evt && pend_valid;
    end

    dwc_tag_store #(
        .INDEX_W (INDEX_W),
        .TAG_W   (TAG_W)
    ) u_tags (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_index   (req_index),
        .rd_tag     (req_tag),
        .rd_hit     (tag_hit),
        .fill_en    (fill_valid),
        .fill_index (fill_index),
        .fill_tag   (fill_tag)
    );

    dwc_data_store #(
        .INDEX_W (INDEX_W),
        .OFF_W   (OFF_W),
        .DATA_W  (DATA_W)
    ) u_data (
        .clk        (clk),
        .rd_index   (req_index),
        .rd_off     (req_off),
        .rd_word    (arr_word),
        .fill_en    (fill_valid),
        .fill_index (fill_index),
        .fill_line  (fill_data),
        .wr_en      (commit_en),
        .wr_index   (pend_index),
        .wr_off     (pend_off),
        .wr_data    (pend_data),
        .wr_be      (pend_be)
    );

    dwc_pend_buf #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .INDEX_W (INDEX_W),
        .OFF_W   (OFF_W)
    ) u_pend (
        .clk         (clk),
        .rst_n       (rst_n),
        .store_evt   (store_evt),
        .store_hit   (tag_hit),
        .cap_addr    (req_addr),
        .cap_data    (req_wdata),
        .cap_be      (req_be),
        .fill_en     (fill_valid),
        .fill_index  (fill_index),
        .pend_valid  (pend_valid),
        .pend_index  (pend_index),
        .pend_off    (pend_off),
        .pend_data   (pend_data),
        .pend_be     (pend_be),
        .look_addr   (req_addr),
        .arr_word    (arr_word),
        .merged_word (rsp_rdata)
    );

    // Response and write-through outputs
    always_comb begin
        rsp_hit  = accepted && tag_hit;
        wt_valid = store_evt;
        wt_addr  = req_addr;
        wt_data  = req_wdata;
        wt_be    = req_be;
    end

endmodule

// File: rtl/dwc_cache_checker.sv
// Module: temporal properties of dwc_cache, attached by bind.
// Assumes: observes ports plus the pending-valid flag of the top.
module dwc_cache_checker #(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 32,
    parameter int INDEX_W = 4,
    parameter int OFF_W   = 2
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      req_valid,
    input logic                      req_store,
    input logic [ADDR_W-1:0]         req_addr,
    input logic [DATA_W-1:0]         req_wdata,
    input logic [DATA_W/8-1:0]       req_be,
    input logic                      fill_valid,
    input logic [ADDR_W-OFF_W-1:0]   fill_addr,
    input logic                      rsp_hit,
    input logic [DATA_W-1:0]         rsp_rdata,
    input logic                      wt_valid,
    input logic                      pend_valid
);
    localparam int BE_W = DATA_W / 8;

    logic [DATA_W-1:0] be_mask;
    logic              st_hit;
    logic              st_miss;
    logic              ld_now;

    // Expand byte enables into a bit mask
    always_comb begin
        for (int b = 0; b < BE_W; b++) begin
            be_mask[b*8 +: 8] = {8{req_be[b]}};
        end
        st_hit  = req_valid && req_store && !fill_valid && rsp_hit;
        st_miss = req_valid && req_store && !fill_valid && !rsp_hit;
        ld_now  = req_valid && !req_store && !fill_valid;
    end

    AST_FILL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |-> (!rsp_hit && !wt_valid)); // R10

    AST_FILL_THEN_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |=> ((req_valid && !fill_valid &&
                         req_addr[ADDR_W-1:OFF_W] == $past(fill_addr)) -> rsp_hit)); // R3

    AST_STORE_MISS_NO_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
        st_miss |=> ((req_valid && !fill_valid &&
                      req_addr[ADDR_W-1:OFF_W] == $past(req_addr[ADDR_W-1:OFF_W])) -> !rsp_hit)); // R7

    AST_STORE_MISS_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        st_miss |=> !pend_valid); // R7

    AST_PEND_FROM_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_valid) |-> $past(st_hit)); // R4

    AST_BYPASS_BYTES: assert property (@(posedge clk) disable iff (!rst_n)
        st_hit |=> ((ld_now && req_addr == $past(req_addr)) ->
                    (((rsp_rdata ^ $past(req_wdata)) & $past(be_mask)) == '0))); // R5

endmodule

bind dwc_cache dwc_cache_checker #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .INDEX_W (INDEX_W),
    .OFF_W   (OFF_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_store  (req_store),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .req_be     (req_be),
    .fill_valid (fill_valid),
    .fill_addr  (fill_addr),
    .rsp_hit    (rsp_hit),
    .rsp_rdata  (rsp_rdata),
    .wt_valid   (wt_valid),
    .pend_valid (pend_valid)
);

// File: tb/dwc_cache_tb.sv
// Bench: sweeps over a 16-line, 4-word configuration. Expected values come
// from a memory model: because the cache is write-through, every present
// line equals memory, so a load that hits must return the memory word.
module dwc_cache_tb;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W  = 16;
    localparam int DATA_W  = 32;
    localparam int INDEX_W = 4;
    localparam int OFF_W   = 2;
    localparam int LINES   = 1 << INDEX_W;
    localparam int WORDS   = 1 << OFF_W;
    localparam int TAG_W   = ADDR_W - INDEX_W - OFF_W;
    localparam int LADDR_W = ADDR_W - OFF_W;
    localparam int BE_W    = DATA_W / 8;
    localparam int LINE_W  = DATA_W * WORDS;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               req_valid = 1'b0;
    logic               req_store = 1'b0;
    logic [ADDR_W-1:0]  req_addr = '0;
    logic [DATA_W-1:0]  req_wdata = '0;
    logic [BE_W-1:0]    req_be = '0;
    logic               rsp_hit;
    logic [DATA_W-1:0]  rsp_rdata;
    logic               wt_valid;
    logic [ADDR_W-1:0]  wt_addr;
    logic [DATA_W-1:0]  wt_data;
    logic [BE_W-1:0]    wt_be;
    logic               fill_valid = 1'b0;
    logic [LADDR_W-1:0] fill_addr = '0;
    logic [LINE_W-1:0]  fill_data = '0;

    int n_checks = 0;
    int n_fail   = 0;

    logic [DATA_W-1:0] mem_q [int];
    logic              m_valid [LINES];
    logic [TAG_W-1:0]  m_tag   [LINES];

    always #(CLK_PERIOD/2) clk = ~clk;

    dwc_cache #(
        .ADDR_W (ADDR_W), .DATA_W (DATA_W), .INDEX_W (INDEX_W), .OFF_W (OFF_W)
    ) u_dut (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_store (req_store), .req_addr (req_addr),
        .req_wdata (req_wdata), .req_be (req_be),
        .rsp_hit (rsp_hit), .rsp_rdata (rsp_rdata),
        .wt_valid (wt_valid), .wt_addr (wt_addr), .wt_data (wt_data), .wt_be (wt_be),
        .fill_valid (fill_valid), .fill_addr (fill_addr), .fill_data (fill_data)
    );

    function automatic logic [ADDR_W-1:0] mk_addr(int tag, int idx, int off);
        return ADDR_W'((tag << (INDEX_W + OFF_W)) | (idx << OFF_W) | off);
    endfunction

    function automatic logic [DATA_W-1:0] mem_rd(logic [ADDR_W-1:0] a);
        if (mem_q.exists(int'(a))) return mem_q[int'(a)];
        return (DATA_W'(a) * 32'h0100_0193) ^ 32'hA5C3_0000;
    endfunction

    function automatic logic [DATA_W-1:0] merge(logic [DATA_W-1:0] old_w,
                                                logic [DATA_W-1:0] new_w,
                                                logic [BE_W-1:0] be);
        logic [DATA_W-1:0] r = old_w;
        for (int b = 0; b < BE_W; b++)
            if (be[b]) r[b*8 +: 8] = new_w[b*8 +: 8];
        return r;
    endfunction

    function automatic logic exp_hit(logic [ADDR_W-1:0] a);
        int idx = int'(a[OFF_W +: INDEX_W]);
        return m_valid[idx] && (m_tag[idx] == a[ADDR_W-1 -: TAG_W]);
    endfunction

    task automatic chk(bit ok, string req, string what, longint act, longint expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0; fill_valid = 1'b0; req_store = 1'b0;
    endtask

    // Load: sample combinational response before the next rising edge
    task automatic do_load(logic [ADDR_W-1:0] a, string req);
        logic eh;
        @(negedge clk);
        fill_valid = 1'b0; req_valid = 1'b1; req_store = 1'b0;
        req_addr = a; req_be = '0;
        #1;
        eh = exp_hit(a);
        chk(rsp_hit == eh, req, "load hit", longint'(rsp_hit), longint'(eh));
        if (eh) chk(rsp_rdata == mem_rd(a), req, "load data",
                    longint'(rsp_rdata), longint'(mem_rd(a)));
    endtask

    // Store: check hit and the write-through port, then update memory
    task automatic do_store(logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d,
                            logic [BE_W-1:0] be, string req);
        logic eh;
        @(negedge clk);
        fill_valid = 1'b0; req_valid = 1'b1; req_store = 1'b1;
        req_addr = a; req_wdata = d; req_be = be;
        #1;
        eh = exp_hit(a);
        chk(rsp_hit == eh, req, "store hit", longint'(rsp_hit), longint'(eh));
        chk(wt_valid && wt_addr == a && wt_data == d && wt_be == be, "R8",
            "write-through", longint'({wt_valid, wt_addr}), longint'({1'b1, a}));
        mem_q[int'(a)] = merge(mem_rd(a), d, be);
    endtask

    // Fill a line from the memory model, optionally with a store presented
    task automatic do_fill(int tag, int idx, bit with_store);
        logic [LINE_W-1:0] ln;
        for (int w = 0; w < WORDS; w++) ln[w*DATA_W +: DATA_W] = mem_rd(mk_addr(tag, idx, w));
        @(negedge clk);
        fill_valid = 1'b1; fill_addr = LADDR_W'((tag << INDEX_W) | idx); fill_data = ln;
        req_valid = with_store; req_store = 1'b1;
        req_addr = mk_addr(tag, idx, 0); req_wdata = 32'hDEAD_BEEF; req_be = '1;
        #1;
        chk(!rsp_hit && !wt_valid, "R10", "fill blocks request",
            longint'({rsp_hit, wt_valid}), 0);
        m_valid[idx] = 1'b1;
        m_tag[idx]   = TAG_W'(tag);
    endtask

    initial begin
        for (int i = 0; i < LINES; i++) begin m_valid[i] = 1'b0; m_tag[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R2: reset state, every index misses
        for (int i = 0; i < LINES; i++) do_load(mk_addr(0, i, i % WORDS), "R2");

        // R3, R1: fill every line with tag 3 and read every word back
        for (int i = 0; i < LINES; i++) begin
            do_fill(3, i, 1'b0);
            for (int w = 0; w < WORDS; w++) do_load(mk_addr(3, i, w), "R3");
        end
        // R1: other tags miss on every index
        for (int i = 0; i < LINES; i++) do_load(mk_addr(4, i, 0), "R1");

        // R4, R5: every byte-enable pattern, load straight after store
        for (int be = 1; be < 16; be++) begin
            for (int i = 0; i < LINES; i++) begin
                logic [ADDR_W-1:0] a = mk_addr(3, i, (i + be) % WORDS);
                do_store(a, 32'h1111_1111 * be ^ (i << 8), BE_W'(be), "R4");
                do_load(a, "R5");
            end
        end

        // R6: back-to-back stores to one word with disjoint enables
        do_store(mk_addr(3, 7, 1), 32'hAABB_CCDD, 4'b0011, "R6");
        do_store(mk_addr(3, 7, 1), 32'h1122_3344, 4'b1100, "R6");
        do_load(mk_addr(3, 7, 1), "R6");
        // R6: back-to-back stores to different words
        do_store(mk_addr(3, 2, 0), 32'h0F0F_0F0F, 4'b1111, "R6");
        do_store(mk_addr(3, 9, 3), 32'hF0F0_F0F0, 4'b0101, "R6");
        do_load(mk_addr(3, 2, 0), "R6");
        do_load(mk_addr(3, 9, 3), "R6");

        // R7: store hit, then store miss on same index, no allocation
        do_store(mk_addr(3, 5, 2), 32'h5555_AAAA, 4'b1111, "R7");
        do_store(mk_addr(9, 5, 2), 32'h7777_8888, 4'b1111, "R7");
        do_load(mk_addr(9, 5, 2), "R7");
        do_load(mk_addr(3, 5, 2), "R7");
        idle();
        do_load(mk_addr(3, 5, 2), "R7");
        do_fill(9, 5, 1'b0);
        do_load(mk_addr(9, 5, 2), "R7");

        // R9: fill on the pending index discards the pending word
        do_fill(3, 6, 1'b0);
        do_store(mk_addr(3, 6, 1), 32'hCAFE_0001, 4'b1111, "R9");
        do_fill(12, 6, 1'b0);
        do_store(mk_addr(3, 0, 0), 32'h0000_1234, 4'b0001, "R9");
        for (int w = 0; w < WORDS; w++) do_load(mk_addr(12, 6, w), "R9");
        // R9: fill elsewhere keeps the pending word
        do_store(mk_addr(3, 2, 3), 32'hBEEF_0002, 4'b1010, "R9");
        do_fill(3, 8, 1'b0);
        do_load(mk_addr(3, 2, 3), "R9");
        do_store(mk_addr(3, 1, 0), 32'h0000_0000, 4'b0000, "R9");
        do_load(mk_addr(3, 2, 3), "R9");

        // R10: store presented during a fill has no effect
        do_fill(3, 11, 1'b1);
        do_load(mk_addr(3, 11, 0), "R10");

        // Mixed random run over a small tag set
        for (int k = 0; k < 3000; k++) begin
            int r = $urandom_range(0, 9);
            int tg = $urandom_range(0, 3);
            int ix = $urandom_range(0, LINES - 1);
            int of = $urandom_range(0, WORDS - 1);
            if (r < 4)       do_load(mk_addr(tg, ix, of), "R1");
            else if (r < 8)  do_store(mk_addr(tg, ix, of), $urandom,
                                      BE_W'($urandom_range(0, 15)), "R6");
            else             do_fill(tg, ix, r == 9);
        end

        // R2: reset again, loads miss
        @(negedge clk); rst_n = 1'b0; req_valid = 1'b0; fill_valid = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        for (int i = 0; i < LINES; i++) m_valid[i] = 1'b0;
        for (int i = 0; i < LINES; i++) do_load(mk_addr(3, i, 0), "R2");

        idle();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog run did not complete actual=hung expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule